// File: doc/BRIEF.md
# Cascaded Converter Readout Node

This block is the digital serial side of one four-channel, 24-bit converter node that can be chained with identical nodes. Every node in a chain shares one chip select, one serial clock and one command line. A host reads all channels of all nodes with one read command under one chip select. Each node answers by shifting out its own four channel words. After those words it passes on, bit for bit, the stream that arrives from the next node further down the chain.

Each node also takes part in a data-ready chain. The first node's data-ready input is tied low. Each node drives its data-ready output low only when its input is low and its own fresh conversion has been captured. The data-ready output of the last node therefore tells the host that every node holds new words. A conversion pulse captures the four channel words into a holding register. The read that follows shifts out that captured set, even if a newer conversion arrives while the read is in progress.

Serial clock and chip select are sampled by the node's system clock and edge-detected, so one clock domain covers the whole block. The serial clock idles high. Commands are sampled on the rising edge and data changes on the falling edge.

Top module: `chain_rd_node`

## Requirements
- R1: While reset is applied, `dout` is 0 and `drdy_out_n` is 1.
- R2: `drdy_out_n` is 0 exactly when `drdy_in_n` is 0 and the node holds a captured conversion not yet read; otherwise it is 1.
- R3: A one-cycle `conv_done` pulse captures `ch_data` and marks the node ready. The ready mark clears at the first data shift of a read frame.
- R4: After chip select falls, the first 8 serial clock rising edges sample `din` MSB first as a command. Only the command 8'hC3 starts a read. Any other value, including one differing by a single bit, does not.
- R5: In a frame whose command is not 8'hC3, `dout` stays 0 for the whole frame and the ready mark is kept.
- R6: In a read frame, the falling edge right after the 8th command bit puts the first data bit on `dout`. Each later falling edge puts out the next bit. The node's own 96 bits come first: channel 0 first, each word MSB first. Channel k sits in `ch_data[24k+23:24k]`.
- R7: After its own 96 bits, the node repeats the bits seen on `casc_in` at successive falling edges (from the second data edge onward), delayed by 96 edges, with no gaps. Two chained nodes thus deliver 192 node bits followed by the far node's cascade input stream.
- R8: Raising chip select forces `dout` to 0 at once and clears the frame. A new frame starts again with a command. A read after an aborted read returns the held words from the first bit.
- R9: The words shifted in a read are those captured before its first data edge. A `conv_done` during the read does not change the stream. It only affects later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select shared by the chain |
| sclk | input | 1 | Serial clock, idle high |
| din | input | 1 | Serial command input |
| dout | output | 1 | Serial data output toward the host or the upstream node |
| casc_in | input | 1 | Serial data from the next node downstream |
| drdy_in_n | input | 1 | Active-low data-ready from the previous node (low on the first node) |
| drdy_out_n | output | 1 | Active-low combined data-ready |
| conv_done | input | 1 | One-cycle pulse: new conversion words are on ch_data |
| ch_data | input | 96 | Four 24-bit channel words, channel k at bits 24k+23 to 24k |

## Verification
The assertions take for granted that `sclk` and `cs_n` are synchronous to `clk`, and that each serial clock level lasts at least two system clocks, so every edge is seen once. They also assume chip select changes only while the serial clock is high, and that `conv_done` is a single-cycle pulse. The stimulus changes every input on the falling system clock edge and holds each serial clock level for four system clocks. It toggles chip select only with the serial clock idle high, and pulses conversion-done for exactly one cycle, mid-frame included.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
   localparam int unsigned DEF_N_CH  = 4;
   localparam int unsigned DEF_CH_W  = 24;
   localparam int unsigned DEF_CMD_W = 8;

   // frame progress after chip select falls
   typedef enum logic [1:0] {
      FR_CMD   = 2'd0,   // collecting command bits
      FR_ARMED = 2'd1,   // read accepted, waiting for first data edge
      FR_SHIFT = 2'd2,   // shifting words and cascade stream
      FR_SKIP  = 2'd3    // unknown command, stay silent
   } frame_ph_t;
endpackage

// File: rtl/chain_rd_cmd.sv
module chain_rd_cmd
   import chain_rd_pkg::*;
#(
   parameter int unsigned        CMD_W  = DEF_CMD_W,
   parameter logic [CMD_W-1:0]   RD_CMD = 'hC3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rise,
   input  logic fall,
   input  logic din,
   output logic start_o,
   output logic shifting_o
);
   localparam int unsigned CNT_W = $clog2(CMD_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

   frame_ph_t          ph;
   logic [CNT_W-1:0]   cnt;
   logic [CMD_W-2:0]   cmd_sr;
   logic [CMD_W-1:0]   nxt;

   assign nxt = {cmd_sr, din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= FR_CMD;
         cnt    <= '0;
         cmd_sr <= '0;
      end else if (cs_n) begin
         ph     <= FR_CMD;
         cnt    <= '0;
         cmd_sr <= '0;
      end else begin
         case (ph)
            FR_CMD: if (rise) begin
               cmd_sr <= nxt[CMD_W-2:0];
               cnt    <= cnt + 1'b1;
               if (cnt == LAST) ph <= (nxt == RD_CMD) ? FR_ARMED : FR_SKIP;
            end
            FR_ARMED: if (fall) ph <= FR_SHIFT;
            default: ;
         endcase
      end
   end

   assign start_o    = (ph == FR_ARMED) && fall && !cs_n;
   assign shifting_o = (ph == FR_SHIFT);

   // R4: a read can only be armed by a command rising edge
   p_arm_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == FR_CMD) |=> (ph != FR_ARMED) || $past(rise));
   // R5: an unknown command keeps the frame silent until chip select rises
   p_skip_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == FR_SKIP && !cs_n) |=> (ph == FR_SKIP));
endmodule

// File: rtl/chain_rd_shift.sv
module chain_rd_shift
   import chain_rd_pkg::*;
#(
   parameter int unsigned N_CH = DEF_N_CH,
   parameter int unsigned CH_W = DEF_CH_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   start_i,
   input  logic                   shifting_i,
   input  logic                   fall_i,
   input  logic                   casc_i,
   input  logic [N_CH*CH_W-1:0]   hold_i,
   output logic                   out_o
);
   localparam int unsigned TOT = N_CH * CH_W;

   logic [TOT-1:0] ordered;
   logic [TOT-1:0] sr;

   // channel 0 lands in the top word so it leaves first
   for (genvar k = 0; k < N_CH; k++) begin : g_order
      assign ordered[(N_CH-1-k)*CH_W +: CH_W] = hold_i[k*CH_W +: CH_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              sr <= '0;
      else if (start_i)                        sr <= ordered;
      else if (shifting_i && fall_i && !cs_n)  sr <= {sr[TOT-2:0], casc_i};
   end

   assign out_o = shifting_i & ~cs_n & sr[TOT-1];

   // R6: the chain register moves only on a serial falling edge
   p_sr_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (shifting_i && !fall_i) |=> $stable(sr));
endmodule

// File: rtl/chain_rd_ready.sv
module chain_rd_ready
   import chain_rd_pkg::*;
#(
   parameter int unsigned N_CH = DEF_N_CH,
   parameter int unsigned CH_W = DEF_CH_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   conv_i,
   input  logic [N_CH*CH_W-1:0]   data_i,
   input  logic                   start_i,
   input  logic                   drdy_in_n,
   output logic [N_CH*CH_W-1:0]   hold_o,
   output logic                   drdy_out_n
);
   logic ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_o <= '0;
         ready  <= 1'b0;
      end else begin
         if (conv_i)       hold_o <= data_i;
         if (conv_i)       ready  <= 1'b1;
         else if (start_i) ready  <= 1'b0;
      end
   end

   assign drdy_out_n = drdy_in_n | ~ready;

   // R3: a conversion pulse marks the node ready
   p_ready_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_i |=> ready);
   // R3: the first data shift consumes the ready mark
   p_ready_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !conv_i) |=> !ready);
   // R9: held words change only on a conversion pulse
   p_hold_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_i |=> $stable(hold_o));
endmodule

// File: rtl/chain_rd_node.sv
module chain_rd_node
   import chain_rd_pkg::*;
#(
   parameter int unsigned      N_CH   = DEF_N_CH,
   parameter int unsigned      CH_W   = DEF_CH_W,
   parameter int unsigned      CMD_W  = DEF_CMD_W,
   parameter logic [CMD_W-1:0] RD_CMD = 'hC3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n,
   input  logic                  sclk,
   input  logic                  din,
   output logic                  dout,
   input  logic                  casc_in,
   input  logic                  drdy_in_n,
   output logic                  drdy_out_n,
   input  logic                  conv_done,
   input  logic [N_CH*CH_W-1:0]  ch_data
);
   localparam int unsigned TOT = N_CH * CH_W;

   if (CMD_W < 2) begin : g_bad_cmd
      $error("chain_rd_node: CMD_W must be at least 2");
   end
   if (N_CH < 1 || CH_W < 1 || TOT < 2) begin : g_bad_word
      $error("chain_rd_node: need at least two data bits per node");
   end

   logic             sclk_q;
   logic             rise, fall;
   logic             start, shifting;
   logic [TOT-1:0]   hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b1;
      else        sclk_q <= sclk;
   end

   assign rise = sclk & ~sclk_q;
   assign fall = ~sclk & sclk_q;

   chain_rd_cmd #(.CMD_W(CMD_W), .RD_CMD(RD_CMD)) u_cmd (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .fall(fall),
      .din(din), .start_o(start), .shifting_o(shifting)
   );

   chain_rd_ready #(.N_CH(N_CH), .CH_W(CH_W)) u_rdy (
      .clk(clk), .rst_n(rst_n), .conv_i(conv_done), .data_i(ch_data),
      .start_i(start), .drdy_in_n(drdy_in_n), .hold_o(hold),
      .drdy_out_n(drdy_out_n)
   );

   chain_rd_shift #(.N_CH(N_CH), .CH_W(CH_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start_i(start),
      .shifting_i(shifting), .fall_i(fall), .casc_i(casc_in),
      .hold_i(hold), .out_o(dout)
   );

   // R8: a raised chip select ends the shifting phase on the next cycle
   p_cs_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !shifting);
   // R6: a read begins on a falling serial edge only
   p_start_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!sclk && sclk_q));
endmodule

// File: tb/chain_rd_node_test.sv
module chain_rd_node_test;
   localparam logic [7:0] RD = 8'hC3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, din = 1'b0, tail = 1'b0;
   logic b_drdy_in_n = 1'b0, conv_a = 1'b0, conv_b = 1'b0;
   logic [95:0] data_a = '0, data_b = '0;
   logic dout_a, dout_b, drdy_a, drdy_b;

   chain_rd_node uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .dout(dout_a), .casc_in(dout_b), .drdy_in_n(drdy_b),
      .drdy_out_n(drdy_a), .conv_done(conv_a), .ch_data(data_a)
   );
   chain_rd_node u_far (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .dout(dout_b), .casc_in(tail), .drdy_in_n(b_drdy_in_n),
      .drdy_out_n(drdy_b), .conv_done(conv_b), .ch_data(data_b)
   );

   int nchk = 0, nbad = 0;
   logic  exp_q[$];
   string tag_q[$];
   logic [95:0] lat_a = '0, lat_b = '0;

   function automatic logic [95:0] stream(input logic [95:0] d);
      logic [95:0] s;
      for (int k = 0; k < 4; k++) s[(3-k)*24 +: 24] = d[k*24 +: 24];
      return s;
   endfunction

   function automatic logic tailpat(input int j);
      return ((j * 5) % 7) < 3;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic half();
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse(input bit a, input bit b);
      @(negedge clk);
      conv_a = a; conv_b = b;
      @(negedge clk);
      conv_a = 1'b0; conv_b = 1'b0;
      if (a) lat_a = data_a;
      if (b) lat_b = data_b;
      #1;
   endtask

   // scoreboard monitor: host samples dout on each rising serial edge
   always @(posedge sclk) begin
      if (!cs_n) begin
         nchk++;
         if (exp_q.size() == 0) begin
            nbad++;
            $display("FAIL R6 unexpected bit actual=%b expected=none", dout_a);
         end else begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (dout_a !== e) begin
               nbad++;
               $display("FAIL %s actual=%b expected=%b", t, dout_a, e);
            end
         end
      end
   end

   // driver: pushes the expected stream and clocks the frame
   task automatic run_frame(input logic [7:0] cmd, input int nbits,
                            input string tag0, input bit mid,
                            input logic [95:0] mid_data);
      logic [95:0] xa, xb;
      bit rd;
      xa = stream(lat_a);
      xb = stream(lat_b);
      rd = (cmd == RD);
      @(negedge clk);
      cs_n = 1'b0;
      half();
      for (int i = 0; i < 8; i++) begin
         sclk = 1'b0; din = cmd[7-i];
         half();
         exp_q.push_back(1'b0); tag_q.push_back("R4");
         sclk = 1'b1;
         half();
      end
      din = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         logic e;
         sclk = 1'b0;
         if (mid && i == 40) begin
            data_a = mid_data; conv_a = 1'b1;
            @(negedge clk);
            conv_a = 1'b0; lat_a = mid_data;
            repeat (3) @(negedge clk);
         end else half();
         if (!rd)          e = 1'b0;
         else if (i < 96)  e = xa[95-i];
         else if (i < 192) e = xb[191-i];
         else              e = tailpat(i - 192);
         exp_q.push_back(e);
         tag_q.push_back(!rd ? "R5" : (i < 96 ? tag0 : "R7"));
         sclk = 1'b1; tail = tailpat(i);
         half();
      end
      cs_n = 1'b1;
      #1 chk("R8", dout_a, 1'b0);
      half();
      nchk++;
      if (exp_q.size() != 0) begin
         nbad++;
         $display("FAIL R6 leftover actual=%0d expected=0", exp_q.size());
         exp_q.delete(); tag_q.delete();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", dout_a, 1'b0);
      chk("R1", drdy_a, 1'b1);
      chk("R1", drdy_b, 1'b1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      data_a = {24'h123456, 24'h800001, 24'h0F0F0F, 24'hA1B2C3};
      data_b = {24'hFEDCBA, 24'h000001, 24'h7FFFFF, 24'h5A5A5A};
      pulse(1, 0);
      chk("R2", drdy_a, 1'b1);   // far node not ready
      pulse(0, 1);
      chk("R2", drdy_b, 1'b0);
      chk("R2", drdy_a, 1'b0);
      @(negedge clk) b_drdy_in_n = 1'b1;
      #1 chk("R2", drdy_a, 1'b1);
      @(negedge clk) b_drdy_in_n = 1'b0;
      #1 chk("R2", drdy_a, 1'b0);

      // R5: unknown command, silent and ready kept
      run_frame(8'h5A, 40, "R6", 0, '0);
      chk("R5", drdy_a, 1'b0);
      // R4: one bit away from the read command
      run_frame(8'hC2, 30, "R6", 0, '0);
      chk("R4", drdy_a, 1'b0);

      // R6/R7: full chain read
      run_frame(RD, 220, "R6", 0, '0);
      chk("R3", drdy_a, 1'b1);
      chk("R3", drdy_b, 1'b1);

      data_a = {24'hAAAAAA, 24'h555555, 24'hFFFFFF, 24'h000000};
      data_b = {24'h0000FF, 24'hFF0000, 24'h00FF00, 24'h3C3C3C};
      pulse(1, 1);
      chk("R3", drdy_a, 1'b0);
      // R8: aborted read, then a complete read from the first bit
      run_frame(RD, 50, "R8", 0, '0);
      run_frame(RD, 200, "R8", 0, '0);

      data_a = {24'h13579B, 24'h2468AC, 24'hDEADBE, 24'h010203};
      pulse(1, 1);
      // R9: conversion during a read leaves the stream alone
      run_frame(RD, 200, "R9", 1, {24'h0C0C0C, 24'hF00F00, 24'h314159, 24'h271828});
      run_frame(RD, 100, "R9", 0, '0);

      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nbad++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule